// File: doc/BRIEF.md
# Setpoint Request Checker and Arbiter

This block takes requests to move the system to one of a small set of numbered operating setpoints and forwards them one at a time to the system-level controller. Requests come from three places. Software asks directly. A request can also be armed to fire on the CPU platform's next sleep sequence, or on its next wakeup sequence. Before a request goes out, it is checked against an allowed-setpoint mask chosen by the CPU's current mode.

An allowed request goes out on a request/acknowledge handshake. On the acknowledge, the current setpoint becomes the previous one and the granted target becomes current. A request that the mask forbids is dropped, and a sticky status flag is set for that request kind. Each flag has its own interrupt enable. Once a lock bit is set, the mode masks and the per-mode standby enables can no longer be written.

Software reaches the block through a simple word-addressed register port with a combinational read. Sleep and wakeup sequence events arrive as one-cycle pulses from the power sequencer.

Top module: `setpoint_req_arbiter`

## Requirements
- R1: Word 0 is the request control word. The software enable is bit 0 and its target is [4:1]. The sleep enable is bit 5 and its target is [9:6]. The wakeup enable is bit 10 and its target is [14:11]. All of these fields read back as written until hardware clears an enable.
- R2: A `sleep_seq_i` pulse latches the sleep target as a pending request and clears the sleep enable, but only when the sleep enable is set. `wakeup_seq_i` does the same with the wakeup fields. A pulse with its enable clear has no effect.
- R3: When idle, a candidate request is checked against the mask of `cpu_mode_i` (0 RUN, 1 WAIT, 2 STOP, 3 SUSPEND). Bit n of that mask allows setpoint n. If allowed, `sp_req_o` rises and `sp_tgt_o` shows the target after the next edge.
- R4: `sp_req_o` and `sp_tgt_o` hold until `sp_ack_i` is seen with the request high. Only one request is outstanding at a time.
- R5: The acknowledge moves current to previous and the target to current. Word 1 shows current in [3:0], previous in [7:4] and the last granted target in [11:8]. The acknowledge of a software request clears the software enable.
- R6: A disallowed request is dropped without a handshake. It sets sticky status bit 16 (sleep), 17 (wakeup) or 18 (software) of word 2. A disallowed software request clears its enable at the same edge.
- R7: Word 2 bits [2:0] are interrupt enables for the sleep, wakeup and software flags. `irq_o` is the OR of each flag ANDed with its enable. Writing 1 to a flag bit clears it, and a new rejection in the same cycle takes priority over the clear.
- R8: A pending sleep request goes first, then a pending wakeup request, then a software request.
- R9: Words 3, 4, 5 and 6 hold the 16-bit masks for RUN, WAIT, STOP and SUSPEND. All four reset to all ones.
- R10: Bit 0 of word 7 is the lock. Writing 1 sets it, and it stays set until reset. While it is set, writes to words 3–6 and to the standby bits of word 7 are ignored.
- R11: Word 7 bits [3:1] enable standby for WAIT, STOP and SUSPEND. `stby_o` is the enable for the current mode, and it is 0 in RUN.
- R12: After reset all control, status, interrupt and lock state is zero and no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for `reg_addr_i` |
| cpu_mode_i | input | 2 | Current CPU mode |
| sleep_seq_i | input | 1 | Sleep sequence event pulse |
| wakeup_seq_i | input | 1 | Wakeup sequence event pulse |
| sp_req_o | output | 1 | Setpoint transition request |
| sp_tgt_o | output | log2(NSP) | Requested setpoint |
| sp_ack_i | input | 1 | Transition done |
| irq_o | output | 1 | Rejection interrupt |
| stby_o | output | 1 | Standby request for the current mode |

## Verification
The bench uses the default parameters: 16 setpoints, a 32-bit data word and eight register words. With these values the fixed field positions, all four mode masks and every target value fall on real bits. A directed prologue covers the sleep-over-wakeup-over-software ordering, rejections against a cleared mask bit, and clear-versus-set races on the flags. A long random phase follows, with mode changes, register writes, sequence pulses and randomly delayed acknowledges. The lock is set last, so that the frozen masks and standby bits can be checked against writes that would otherwise change them.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned NMODE = 4;
  localparam logic [1:0] SRC_SLP  = 2'd0;
  localparam logic [1:0] SRC_WK   = 2'd1;
  localparam logic [1:0] SRC_SW   = 2'd2;
  localparam logic [1:0] MODE_RUN = 2'd0;
  localparam int unsigned IST_LO  = 16;
  localparam int unsigned WA_CTRL = 0;
  localparam int unsigned WA_STAT = 1;
  localparam int unsigned WA_INT  = 2;
  localparam int unsigned WA_MAP0 = 3;
  localparam int unsigned WA_LOCK = 7;

  // bit position of a source's enable in the control word
  function automatic int unsigned fld_base(int unsigned src, int unsigned spw);
    case (src)
      2:       return 0;
      0:       return spw + 1;
      default: return 2 * (spw + 1);
    endcase
  endfunction
endpackage

// File: rtl/sp_cfg.sv
module sp_cfg
  import sp_arb_pkg::*;
#(
  parameter int unsigned NSP = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NMODE-1:0]            map_we_i,
  input  logic [NSP-1:0]              map_wdata_i,
  input  logic                        lk_we_i,
  input  logic                        lk_set_i,
  input  logic [NMODE-2:0]            stby_wdata_i,
  input  logic [1:0]                  mode_i,
  output logic [NMODE-1:0][NSP-1:0]   map_o,
  output logic                        lock_o,
  output logic [NMODE-2:0]            stby_en_o,
  output logic [NSP-1:0]              allow_o,
  output logic                        stby_o
);
  logic                      lock_q;
  logic [NMODE-2:0]          stby_q;
  logic [NMODE-1:0][NSP-1:0] map_q;
  logic [NMODE-1:0]          stby_ext;

  for (genvar m = 0; m < NMODE; m++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        map_q[m] <= '1;
      else if (map_we_i[m] && !lock_q)    map_q[m] <= map_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      stby_q <= '0;
    end else if (lk_we_i) begin
      if (lk_set_i) lock_q <= 1'b1;
      if (!lock_q)  stby_q <= stby_wdata_i;
    end
  end

  assign stby_ext  = {stby_q, 1'b0};  // RUN never requests standby
  assign stby_o    = stby_ext[mode_i];
  assign allow_o   = map_q[mode_i];
  assign map_o     = map_q;
  assign lock_o    = lock_q;
  assign stby_en_o = stby_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R10
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(map_q) && $stable(stby_q))); // R10
endmodule

// File: rtl/sp_src.sv
module sp_src
  import sp_arb_pkg::*;
#(
  parameter int unsigned NSP = 16,
  localparam int unsigned SPW = $clog2(NSP),
  localparam int unsigned CTRL_W = 3 * (SPW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [1:0]        seq_i,       // [0] sleep, [1] wakeup
  input  logic              busy_i,
  input  logic [NSP-1:0]    allow_i,
  input  logic              ack_sw_i,
  output logic [CTRL_W-1:0] ctrl_rd_o,
  output logic              issue_o,
  output logic [1:0]        issue_src_o,
  output logic [SPW-1:0]    issue_tgt_o,
  output logic [NSRC-1:0]   rej_o
);
  logic [NSRC-1:0] en_q;
  logic [SPW-1:0]  tgt_q [NSRC];
  logic [1:0]      pend_q;
  logic [SPW-1:0]  ptgt_q [2];

  logic            cand_v, cand_ok;
  logic [1:0]      cand_src;
  logic [SPW-1:0]  cand_tgt;

  // sequence-triggered requests win over software
  always_comb begin
    cand_v   = 1'b0;
    cand_src = SRC_SW;
    cand_tgt = tgt_q[SRC_SW];
    if (!busy_i) begin
      if (pend_q[SRC_SLP]) begin
        cand_v = 1'b1; cand_src = SRC_SLP; cand_tgt = ptgt_q[SRC_SLP];
      end else if (pend_q[SRC_WK]) begin
        cand_v = 1'b1; cand_src = SRC_WK;  cand_tgt = ptgt_q[SRC_WK];
      end else if (en_q[SRC_SW]) begin
        cand_v = 1'b1;
      end
    end
  end

  assign cand_ok     = allow_i[cand_tgt];
  assign issue_o     = cand_v && cand_ok;
  assign issue_src_o = cand_src;
  assign issue_tgt_o = cand_tgt;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      rej_o[i] = cand_v && !cand_ok && (cand_src == 2'(i));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int unsigned B = fld_base(s, SPW);
    logic           en_r, clr;
    logic [SPW-1:0] tgt_r;

    if (s == SRC_SW) begin : g_sw
      assign clr = rej_o[s] | ack_sw_i;
    end else begin : g_seq
      logic           pend_r;
      logic [SPW-1:0] ptgt_r;
      assign clr = seq_i[s] & en_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_r <= 1'b0;
          ptgt_r <= '0;
        end else begin
          if (cand_v && cand_src == 2'(s)) pend_r <= 1'b0;
          if (clr) begin
            pend_r <= 1'b1;
            ptgt_r <= tgt_r;
          end
        end
      end
      assign pend_q[s] = pend_r;
      assign ptgt_q[s] = ptgt_r;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_r  <= 1'b0;
        tgt_r <= '0;
      end else begin
        if (ctrl_we_i) begin
          en_r  <= ctrl_wdata_i[B];
          tgt_r <= ctrl_wdata_i[B+1 +: SPW];
        end
        if (clr) en_r <= 1'b0;  // hardware clear beats a write
      end
    end
    assign en_q[s]  = en_r;
    assign tgt_q[s] = tgt_r;
  end

  always_comb begin
    ctrl_rd_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      ctrl_rd_o[fld_base(s, SPW)]            = en_q[s];
      ctrl_rd_o[fld_base(s, SPW) + 1 +: SPW] = tgt_q[s];
    end
  end

  AST_SW_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o[SRC_SW] |=> !en_q[SRC_SW]); // R6
  AST_SEQ_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_i[SRC_SLP] && en_q[SRC_SLP]) |=> (!en_q[SRC_SLP] && pend_q[SRC_SLP])); // R2
endmodule

// File: rtl/sp_hs.sv
module sp_hs
  import sp_arb_pkg::*;
#(
  parameter int unsigned SPW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           issue_i,
  input  logic [1:0]     issue_src_i,
  input  logic [SPW-1:0] issue_tgt_i,
  input  logic           ack_i,
  output logic           req_o,
  output logic [SPW-1:0] tgt_o,
  output logic           ack_sw_o,
  output logic [SPW-1:0] cur_o,
  output logic [SPW-1:0] prev_o,
  output logic [SPW-1:0] stgt_o
);
  logic           busy_q;
  logic [1:0]     src_q;
  logic [SPW-1:0] tgt_q, cur_q, prev_q, stgt_q;
  logic           done;

  assign done = busy_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      src_q  <= SRC_SW;
      tgt_q  <= '0;
      cur_q  <= '0;
      prev_q <= '0;
      stgt_q <= '0;
    end else if (issue_i) begin
      busy_q <= 1'b1;
      src_q  <= issue_src_i;
      tgt_q  <= issue_tgt_i;
      stgt_q <= issue_tgt_i;
    end else if (done) begin
      busy_q <= 1'b0;
      prev_q <= cur_q;
      cur_q  <= tgt_q;
    end
  end

  assign req_o    = busy_q;
  assign tgt_o    = tgt_q;
  assign ack_sw_o = done && (src_q == SRC_SW);
  assign cur_o    = cur_q;
  assign prev_o   = prev_q;
  assign stgt_o   = stgt_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i) |=> (busy_q && $stable(tgt_q))); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !busy_q); // R4
  AST_ACK_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (!busy_q && cur_q == $past(tgt_q) && prev_q == $past(cur_q))); // R5
endmodule

// File: rtl/sp_irq.sv
module sp_irq
  import sp_arb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic [NSRC-1:0] clr_wdata_i,
  input  logic [NSRC-1:0] set_i,
  output logic [NSRC-1:0] ien_o,
  output logic [NSRC-1:0] ist_o,
  output logic            irq_o
);
  logic [NSRC-1:0] ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ien_q <= '0;
    else if (we_i) ien_q <= en_wdata_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_st
    logic st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         st_q <= 1'b0;
      else if (set_i[i])                   st_q <= 1'b1;
      else if (we_i && clr_wdata_i[i])     st_q <= 1'b0;
    end
    assign ist_o[i] = st_q;

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q && !(we_i && clr_wdata_i[i])) |=> st_q); // R6
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> st_q); // R7
  end

  assign ien_o = ien_q;
  assign irq_o = |(ien_q & ist_o);
endmodule

// File: rtl/setpoint_req_arbiter.sv
module setpoint_req_arbiter
  import sp_arb_pkg::*;
#(
  parameter int unsigned NSP = 16,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 3,
  localparam int unsigned SPW    = $clog2(NSP),
  localparam int unsigned CTRL_W = 3 * (SPW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic [1:0]     cpu_mode_i,
  input  logic           sleep_seq_i,
  input  logic           wakeup_seq_i,
  output logic           sp_req_o,
  output logic [SPW-1:0] sp_tgt_o,
  input  logic           sp_ack_i,
  output logic           irq_o,
  output logic           stby_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(WA_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(WA_STAT);
  localparam logic [AW-1:0] A_INT  = AW'(WA_INT);
  localparam logic [AW-1:0] A_LOCK = AW'(WA_LOCK);

  logic                      ctrl_we, int_we, lk_we;
  logic [NMODE-1:0]          map_we;
  logic [CTRL_W-1:0]         ctrl_rd;
  logic [NMODE-1:0][NSP-1:0] map_q;
  logic [NSP-1:0]            allow;
  logic                      lock;
  logic [NMODE-2:0]          stby_en;
  logic                      issue, ack_sw;
  logic [1:0]                issue_src;
  logic [SPW-1:0]            issue_tgt, cur, prev, stgt;
  logic [NSRC-1:0]           rej, ien, ist;
  logic                      unused_wd;

  assign ctrl_we = reg_we_i && (reg_addr_i == A_CTRL);
  assign int_we  = reg_we_i && (reg_addr_i == A_INT);
  assign lk_we   = reg_we_i && (reg_addr_i == A_LOCK);
  for (genvar m = 0; m < NMODE; m++) begin : g_mwe
    assign map_we[m] = reg_we_i && (reg_addr_i == AW'(WA_MAP0 + m));
  end
  assign unused_wd = ^{reg_wdata_i[DW-1:IST_LO+NSRC], reg_wdata_i[IST_LO-1:CTRL_W]};

  sp_cfg #(.NSP(NSP)) u_cfg (
    .clk_i, .rst_ni,
    .map_we_i     (map_we),
    .map_wdata_i  (reg_wdata_i[NSP-1:0]),
    .lk_we_i      (lk_we),
    .lk_set_i     (reg_wdata_i[0]),
    .stby_wdata_i (reg_wdata_i[NMODE-1:1]),
    .mode_i       (cpu_mode_i),
    .map_o        (map_q),
    .lock_o       (lock),
    .stby_en_o    (stby_en),
    .allow_o      (allow),
    .stby_o       (stby_o)
  );

  sp_src #(.NSP(NSP)) u_src (
    .clk_i, .rst_ni,
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (reg_wdata_i[CTRL_W-1:0]),
    .seq_i        ({wakeup_seq_i, sleep_seq_i}),
    .busy_i       (sp_req_o),
    .allow_i      (allow),
    .ack_sw_i     (ack_sw),
    .ctrl_rd_o    (ctrl_rd),
    .issue_o      (issue),
    .issue_src_o  (issue_src),
    .issue_tgt_o  (issue_tgt),
    .rej_o        (rej)
  );

  sp_hs #(.SPW(SPW)) u_hs (
    .clk_i, .rst_ni,
    .issue_i     (issue),
    .issue_src_i (issue_src),
    .issue_tgt_i (issue_tgt),
    .ack_i       (sp_ack_i),
    .req_o       (sp_req_o),
    .tgt_o       (sp_tgt_o),
    .ack_sw_o    (ack_sw),
    .cur_o       (cur),
    .prev_o      (prev),
    .stgt_o      (stgt)
  );

  sp_irq u_irq (
    .clk_i, .rst_ni,
    .we_i        (int_we),
    .en_wdata_i  (reg_wdata_i[NSRC-1:0]),
    .clr_wdata_i (reg_wdata_i[IST_LO +: NSRC]),
    .set_i       (rej),
    .ien_o       (ien),
    .ist_o       (ist),
    .irq_o       (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL) reg_rdata_o[CTRL_W-1:0] = ctrl_rd;
    if (reg_addr_i == A_STAT) reg_rdata_o[3*SPW-1:0]  = {stgt, prev, cur};
    if (reg_addr_i == A_INT) begin
      reg_rdata_o[NSRC-1:0]        = ien;
      reg_rdata_o[IST_LO +: NSRC]  = ist;
    end
    for (int m = 0; m < NMODE; m++)
      if (reg_addr_i == AW'(WA_MAP0 + m)) reg_rdata_o[NSP-1:0] = map_q[m];
    if (reg_addr_i == A_LOCK) reg_rdata_o[NMODE-1:0] = {stby_en, lock};
  end

  AST_ONE_DECISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({issue, rej})); // R3
  AST_REJ_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rej && !sp_req_o) |=> !sp_req_o); // R6
endmodule

// File: tb/setpoint_req_arbiter_tb.sv
module setpoint_req_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [1:0]  mode = '0;
  logic        slp = 1'b0, wk = 1'b0, ack = 1'b0;
  logic [31:0] rdata;
  logic        req, irq, stby;
  logic [3:0]  tgt;

  int checks = 0, fails = 0;
  bit chk_on = 0;
  string tag = "R12";

  // reference state; index 0 sleep, 1 wakeup, 2 software
  int m_en[3], m_tg[3], m_pd[2], m_pt[2], m_map[4], m_ien, m_ist;
  int m_busy, m_src, m_ft, m_cur, m_prev, m_st, m_lock, m_stby;
  int pos[3] = '{5, 10, 0};

  always #10 clk = ~clk;

  setpoint_req_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .cpu_mode_i(mode),
    .sleep_seq_i(slp), .wakeup_seq_i(wk), .sp_req_o(req), .sp_tgt_o(tgt),
    .sp_ack_i(ack), .irq_o(irq), .stby_o(stby)
  );

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_en[i] = 0; m_tg[i] = 0; end
    for (int i = 0; i < 2; i++) begin m_pd[i] = 0; m_pt[i] = 0; end
    for (int i = 0; i < 4; i++) m_map[i] = 'hFFFF;
    m_ien = 0; m_ist = 0; m_busy = 0; m_src = 2; m_ft = 0;
    m_cur = 0; m_prev = 0; m_st = 0; m_lock = 0; m_stby = 0;
  endtask

  task automatic model_step();
    int n_en[3], n_tg[3], n_pd[2], n_pt[2], n_map[4];
    int n_ien, n_ist, n_busy, n_src, n_ft, n_cur, n_prev, n_st, n_lock, n_stby;
    int pick, t, ok, w;
    n_en = m_en; n_tg = m_tg; n_pd = m_pd; n_pt = m_pt; n_map = m_map;
    n_ien = m_ien; n_ist = m_ist; n_busy = m_busy; n_src = m_src; n_ft = m_ft;
    n_cur = m_cur; n_prev = m_prev; n_st = m_st; n_lock = m_lock; n_stby = m_stby;
    w = int'(wd);
    if (we) begin
      if (addr == 0)
        for (int i = 0; i < 3; i++) begin
          n_en[i] = (w >> pos[i]) & 1; n_tg[i] = (w >> (pos[i] + 1)) & 15;
        end
      if (addr == 2) begin n_ien = w & 7; n_ist = m_ist & ~((w >> 16) & 7); end
      if (addr >= 3 && addr <= 6 && !m_lock) n_map[addr-3] = w & 'hFFFF;
      if (addr == 7) begin
        if (w & 1) n_lock = 1;
        if (!m_lock) n_stby = (w >> 1) & 7;
      end
    end
    pick = -1; t = 0;
    if (!m_busy) begin
      if (m_pd[0]) begin pick = 0; t = m_pt[0]; end
      else if (m_pd[1]) begin pick = 1; t = m_pt[1]; end
      else if (m_en[2]) begin pick = 2; t = m_tg[2]; end
    end
    if (pick >= 0) begin
      ok = (m_map[mode] >> t) & 1;
      if (pick < 2) n_pd[pick] = 0;
      if (ok) begin n_busy = 1; n_src = pick; n_ft = t; n_st = t; end
      else begin
        n_ist = n_ist | (1 << pick);
        if (pick == 2) n_en[2] = 0;
      end
    end
    if (slp && m_en[0]) begin n_pd[0] = 1; n_pt[0] = m_tg[0]; n_en[0] = 0; end
    if (wk && m_en[1]) begin n_pd[1] = 1; n_pt[1] = m_tg[1]; n_en[1] = 0; end
    if (m_busy && ack) begin
      n_busy = 0; n_prev = m_cur; n_cur = m_ft;
      if (m_src == 2) n_en[2] = 0;
    end
    m_en = n_en; m_tg = n_tg; m_pd = n_pd; m_pt = n_pt; m_map = n_map;
    m_ien = n_ien; m_ist = n_ist; m_busy = n_busy; m_src = n_src; m_ft = n_ft;
    m_cur = n_cur; m_prev = n_prev; m_st = n_st; m_lock = n_lock; m_stby = n_stby;
  endtask

  function automatic int exp_rd(int a);
    int v;
    v = 0;
    case (a)
      0: for (int i = 0; i < 3; i++) v |= (m_en[i] << pos[i]) | (m_tg[i] << (pos[i] + 1));
      1: v = m_cur | (m_prev << 4) | (m_st << 8);
      2: v = m_ien | (m_ist << 16);
      7: v = m_lock | (m_stby << 1);
      default: v = m_map[a-3];
    endcase
    return v;
  endfunction

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  always @(negedge clk) begin
    if (chk_on) begin
      cmp("sp_req_o", int'(req), m_busy);
      cmp("sp_tgt_o", int'(tgt), m_ft);
      cmp("irq_o", int'(irq), ((m_ien & m_ist) != 0) ? 1 : 0);
      cmp("stby_o", int'(stby), (mode == 0) ? 0 : ((m_stby >> (mode - 1)) & 1));
      cmp("reg_rdata_o", int'(rdata), exp_rd(int'(addr)));
    end
  end

  task automatic step(bit w_e, int a, int d, bit s, bit k, bit ac);
    @(posedge clk); #3;
    we = w_e; addr = 3'(a); wd = 32'(d); slp = s; wk = k; ack = ac;
  endtask

  task automatic idle(int n, int a);
    for (int i = 0; i < n; i++) step(0, a, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1; chk_on = 1;
    tag = "R12";                                   // reset values on all words
    for (int a = 0; a < 8; a++) step(0, a, 0, 0, 0, 0);
    tag = "R1";                                    // control fields read back
    step(1, 0, (3 << 1) | (1 << 5) | (5 << 6) | (1 << 10) | (9 << 11), 0, 0, 0);
    idle(2, 0);
    tag = "R2";                                    // sleep pulse arms and fires
    step(0, 1, 0, 1, 0, 0);
    idle(2, 1);
    tag = "R4";                                    // request held without ack
    idle(4, 0);
    tag = "R5";                                    // ack updates status
    step(0, 1, 0, 0, 0, 1);
    idle(2, 1);
    tag = "R6";                                    // STOP mask forbids 9
    mode = 2;
    step(1, 5, 'hFFFF & ~(1 << 9), 0, 0, 0);
    step(0, 2, 0, 0, 1, 0);
    idle(2, 2);
    step(1, 0, 1 | (9 << 1), 0, 0, 0);
    idle(2, 0);
    step(1, 0, 1 | (4 << 1), 0, 0, 0);
    idle(3, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(2, 0);
    tag = "R7";                                    // enables, W1C, set priority
    step(1, 2, 7, 0, 0, 0);
    idle(1, 2);
    step(1, 2, 7 | (1 << 17), 0, 0, 0);
    idle(1, 2);
    step(1, 0, 1 | (9 << 1), 0, 0, 0);
    step(1, 2, 7 | (7 << 16), 0, 0, 0);
    idle(2, 2);
    step(1, 2, 7 << 16, 0, 0, 0);
    idle(1, 2);
    tag = "R8";                                    // sleep, then wakeup, then software
    step(1, 0, (1 << 5) | (6 << 6) | (1 << 10) | (7 << 11), 0, 0, 0);
    step(1, 0, 1 | (2 << 1) | (1 << 5) | (6 << 6) | (1 << 10) | (7 << 11), 1, 1, 0);
    for (int r = 0; r < 3; r++) begin
      idle(2, 1);
      step(0, 1, 0, 0, 0, 1);
    end
    idle(2, 0);
    tag = "R9";                                    // per-mode masks
    for (int m = 0; m < 4; m++) begin
      step(1, 3 + m, 'h1111 << m, 0, 0, 0);
      idle(1, 3 + m);
    end
    tag = "R11";                                   // standby per mode
    step(1, 7, 'b1010, 0, 0, 0);
    for (int m = 0; m < 4; m++) begin mode = 2'(m); idle(1, 7); end
    tag = "R3";                                    // random traffic against masks
    for (int i = 0; i < 4000; i++) begin
      int a, d;
      a = int'($urandom % 8);
      d = int'($urandom);
      if (a == 7) d = d & ~1;
      @(posedge clk); #3;
      mode = 2'($urandom % 4);
      we = ($urandom % 4) == 0;
      addr = 3'(a); wd = 32'(d);
      slp = ($urandom % 8) == 0;
      wk = ($urandom % 8) == 0;
      ack = (m_busy != 0) && (($urandom % 3) == 0);
    end
    idle(1, 0);
    tag = "R10";                                   // lock freezes masks and standby
    step(1, 7, 'b0101, 0, 0, 0);
    step(1, 7, 'b1110, 0, 0, 0);
    idle(1, 7);
    step(1, 3, 0, 0, 0, 0);
    idle(1, 3);
    step(1, 6, 'h1234, 0, 0, 0);
    idle(1, 6);
    step(1, 7, 0, 0, 0, 0);
    idle(2, 7);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule